// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read Timing

This block buffers words between a write clock domain and an unrelated read clock domain. A strap input, captured only while master reset is held, picks one of two read timings. In standard timing, a word reaches the output bus only when the reader issues an explicit read. In fall-through timing, the oldest word moves to the output bus by itself, and each read advances to the next word.

The two status outputs change their meaning with the timing mode. The read-side output is an empty flag in standard timing and an output-ready indication in fall-through timing. The write-side output is a full flag in standard timing and an input-ready indication in fall-through timing. A half-full flag works in both modes. All status outputs are active low.

Master reset re-samples the strap and clears both pointers. Partial reset clears both pointers but keeps the selected timing. Retransmit rewinds only the read pointer, so stored words can be read again. Pointers cross between the clock domains as gray code through two-flop synchronisers. Both clocks must run while master reset is held low.

Top module: `dcf_fifo`

## Requirements
- R1: `fwft_strap` is sampled only while `mrst_n` is low (1 = fall-through, 0 = standard). Changing it afterwards has no effect until the next master reset.
- R2: In standard mode, a word written into an empty FIFO does not reach `rd_data` until a rising `rd_clk` edge with `rd_en_n` low. `empty_or_n` (low = empty) goes high after the second `rd_clk` edge that follows the write edge.
- R3: In fall-through mode, the first word written into an empty FIFO appears on `rd_data`, with `empty_or_n` low (low = output ready), after the third `rd_clk` edge that follows the write edge. No read enable is needed for this.
- R4: In fall-through mode, `rd_data` holds its word until a rising `rd_clk` edge with `rd_en_n` low. On that edge the next stored word replaces it. If no word is stored, `empty_or_n` goes high.
- R5: In standard mode, `full_ir_n` is low when the memory holds DEPTH words. In fall-through mode, `full_ir_n` is low while the memory can accept a word. Fall-through mode holds DEPTH+1 words: DEPTH in memory plus the output word.
- R6: `half_full_n` is low when the memory holds more than DEPTH/2 words, as counted in the write domain. A word moved to the fall-through output word no longer counts.
- R7: A write while the memory is full is ignored. No stored word is overwritten.
- R8: A read while nothing is available is ignored. `rd_data` holds its value and the read pointer does not move.
- R9: After master reset, the FIFO is empty. In standard mode, `empty_or_n`=0 and `full_ir_n`=1. In fall-through mode, `empty_or_n`=1 and `full_ir_n`=0.
- R10: Partial reset (`prst_n` low) empties the FIFO and keeps the timing mode selected at the last master reset.
- R11: `rt_n` low on a rising `rd_clk` edge moves the read pointer to the first memory location, and any concurrent read is dropped. In fall-through mode the output word is invalidated, and the first stored word is reloaded on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; clears pointers asynchronously and samples the strap |
| prst_n | input | 1 | Partial reset, active low; clears pointers and keeps the mode |
| fwft_strap | input | 1 | Timing mode strap: 1 = fall-through, 0 = standard |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Write data |
| full_ir_n | output | 1 | Full flag (standard) or input ready (fall-through), active low |
| half_full_n | output | 1 | Half-full flag, active low |
| rd_en_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit, active low |
| rd_data | output | DATA_W | Output word |
| empty_or_n | output | 1 | Empty flag (standard) or output ready (fall-through), active low |

## Verification
A write edge reaches the read side through the two synchroniser flops. The empty flag therefore clears after the second `rd_clk` edge, and the fall-through output loads on the third. A read, a retransmit and the full-side flags react on the edge where they are sampled. The bench runs both clocks at the same period with the read clock offset by a quarter period. It drives inputs and samples outputs on falling edges, and counts rising `rd_clk` edges after each write, so that every check falls in the cycle just before or just after its result is due.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              ptr_rst_n,
    input  logic              mrst_n,
    input  logic              mode_strap,
    input  logic              wr_en_n,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              wr_fire,
    output logic              full_ir_n,
    output logic              half_full_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } wptr_t;

    wptr_t         st_d, st_q;
    rd_mode_e      mode_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] occ;
    logic          full;

    always_comb begin
        for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_sync >> i);
        occ     = st_q.bin - rbin;
        full    = (occ == PW'(DEPTH));
        wr_fire = !wr_en_n && !full;
        st_d    = st_q;
        if (wr_fire) st_d.bin = st_q.bin + PW'(1);
        st_d.gray = (st_d.bin >> 1) ^ st_d.bin;
    end

    always_ff @(posedge wr_clk or negedge ptr_rst_n) begin
        if (!ptr_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    always_ff @(posedge wr_clk) begin
        if (!mrst_n) mode_q <= mode_strap ? MODE_FWFT : MODE_STD;
    end

    assign wgray       = st_q.gray;
    assign waddr       = st_q.bin[ADDR_W-1:0];
    assign full_ir_n   = (mode_q == MODE_FWFT) ? full : !full;
    assign half_full_n = !(occ > PW'(HALF));

    // R7: the synchronised read pointer never lets the count pass DEPTH
    a_r7_no_overflow: assert property (@(posedge wr_clk) disable iff (!ptr_rst_n)
        occ <= PW'(DEPTH));

    // R5: flag logic relies on the write pointer moving one gray bit per step
    a_r5_wgray_single_step: assert property (@(posedge wr_clk) disable iff (!ptr_rst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

    // R1: the mode register is frozen outside master reset
    a_r1_wr_mode_fixed: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              rd_clk,
    input  logic              ptr_rst_n,
    input  logic              mrst_n,
    input  logic              mode_strap,
    input  logic              rd_en_n,
    input  logic              rt_n,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_or_n
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0]     bin;
        logic [PW-1:0]     gray;
        logic              ov;
        logic [DATA_W-1:0] dout;
    } rstate_t;

    rstate_t  st_d, st_q;
    rd_mode_e mode_q;
    logic     fwft;
    logic     stored;
    logic     rd_take;
    logic     load;

    always_comb begin
        fwft    = (mode_q == MODE_FWFT);
        stored  = (st_q.gray != wgray_sync);
        if (fwft) begin
            rd_take = !rd_en_n && st_q.ov;
            load    = stored && (!st_q.ov || rd_take);
        end else begin
            rd_take = !rd_en_n && stored;
            load    = rd_take;
        end
        st_d = st_q;
        if (!rt_n) begin
            st_d.bin = '0;
            st_d.ov  = 1'b0;
        end else if (load) begin
            st_d.dout = mem_rdata;
            st_d.bin  = st_q.bin + PW'(1);
            st_d.ov   = fwft;
        end else if (rd_take) begin
            st_d.ov   = 1'b0;
        end
        st_d.gray = (st_d.bin >> 1) ^ st_d.bin;
    end

    always_ff @(posedge rd_clk or negedge ptr_rst_n) begin
        if (!ptr_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    always_ff @(posedge rd_clk) begin
        if (!mrst_n) mode_q <= mode_strap ? MODE_FWFT : MODE_STD;
    end

    assign raddr      = st_q.bin[ADDR_W-1:0];
    assign rgray      = st_q.gray;
    assign rd_data    = st_q.dout;
    assign empty_or_n = fwft ? !st_q.ov : stored;

    // R4: a valid fall-through word stays put until read or rewound
    a_r4_hold_output: assert property (@(posedge rd_clk) disable iff (!ptr_rst_n)
        (fwft && st_q.ov && rd_en_n && rt_n) |=> (st_q.ov && $stable(rd_data)));

    // R8: standard-mode read with nothing stored leaves the output alone
    a_r8_no_underflow: assert property (@(posedge rd_clk) disable iff (!ptr_rst_n)
        (!fwft && !stored) |=> $stable(rd_data));

    // R11: retransmit leaves the read pointer at the first location
    a_r11_rewind: assert property (@(posedge rd_clk) disable iff (!ptr_rst_n)
        !rt_n |=> (raddr == '0 && !st_q.ov));

    // R1: the mode register is frozen outside master reset
    a_r1_rd_mode_fixed: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              fwft_strap,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_ir_n,
    output logic              half_full_n,
    input  logic              rd_en_n,
    input  logic              rt_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_or_n
);
    localparam int PW = ADDR_W + 1;

    logic              ptr_rst_n;
    logic [PW-1:0]     wgray, wgray_sync, rgray, rgray_sync;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              wr_fire;
    logic [DATA_W-1:0] mem_rdata;

    assign ptr_rst_n = mrst_n & prst_n;

    dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk      (wr_clk),
        .ptr_rst_n   (ptr_rst_n),
        .mrst_n      (mrst_n),
        .mode_strap  (fwft_strap),
        .wr_en_n     (wr_en_n),
        .rgray_sync  (rgray_sync),
        .wgray       (wgray),
        .waddr       (waddr),
        .wr_fire     (wr_fire),
        .full_ir_n   (full_ir_n),
        .half_full_n (half_full_n)
    );

    dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rd_clk     (rd_clk),
        .ptr_rst_n  (ptr_rst_n),
        .mrst_n     (mrst_n),
        .mode_strap (fwft_strap),
        .rd_en_n    (rd_en_n),
        .rt_n       (rt_n),
        .wgray_sync (wgray_sync),
        .mem_rdata  (mem_rdata),
        .raddr      (raddr),
        .rgray      (rgray),
        .rd_data    (rd_data),
        .empty_or_n (empty_or_n)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_fire),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk   (rd_clk),
        .rst_n (ptr_rst_n),
        .d     (wgray),
        .q     (wgray_sync)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk   (wr_clk),
        .rst_n (ptr_rst_n),
        .d     (rgray),
        .q     (rgray_sync)
    );
endmodule

// File: tb/dcf_fifo_tb.sv
module dcf_fifo_tb;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int NVEC   = 12;
    localparam logic [7:0] VEC [NVEC] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66,
                                          8'h77, 8'h88, 8'h99, 8'hAA, 8'hBB, 8'hCC};

    logic wr_clk, rd_clk, mrst_n, prst_n, fwft_strap;
    logic wr_en_n, rd_en_n, rt_n;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic full_ir_n, half_full_n, empty_or_n;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    dcf_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_strap(fwft_strap), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .full_ir_n(full_ir_n), .half_full_n(half_full_n), .rd_en_n(rd_en_n),
        .rt_n(rt_n), .rd_data(rd_data), .empty_or_n(empty_or_n)
    );

    initial begin
        wr_clk = 0;
        forever #2 wr_clk = ~wr_clk;
    end
    initial begin
        rd_clk = 0;
        #1;
        forever #2 rd_clk = ~rd_clk;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_mrst(input logic m);
        @(negedge wr_clk);
        mrst_n = 0;
        fwft_strap = m;
        repeat (3) @(negedge wr_clk);
        mrst_n = 1;
        fwft_strap = !m;
        @(negedge rd_clk);
    endtask

    task automatic do_prst();
        @(negedge wr_clk);
        prst_n = 0;
        @(negedge wr_clk);
        prst_n = 1;
        @(negedge rd_clk);
    endtask

    task automatic write_word(input logic [7:0] d);
        @(negedge wr_clk);
        wr_en_n = 0;
        wr_data = d;
        @(negedge wr_clk);
        wr_en_n = 1;
    endtask

    task automatic read_pulse();
        @(negedge rd_clk);
        rd_en_n = 0;
        @(negedge rd_clk);
        rd_en_n = 1;
    endtask

    task automatic rt_pulse();
        @(negedge rd_clk);
        rt_n = 0;
        @(negedge rd_clk);
        rt_n = 1;
    endtask

    initial begin
        repeat (50000) @(posedge wr_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        mrst_n = 0; prst_n = 1; fwft_strap = 0;
        wr_en_n = 1; rd_en_n = 1; rt_n = 1; wr_data = '0;

        // ---------------- standard mode ----------------
        do_mrst(1'b0);
        check("R9 std empty flag", int'(empty_or_n), 0);
        check("R9 std full flag", int'(full_ir_n), 1);
        check("R9 half flag", int'(half_full_n), 1);
        check("R1 strap ignored after reset", int'(empty_or_n), 0);

        write_word(8'hA5);
        @(negedge rd_clk);
        check("R2 empty after 1 rd edge", int'(empty_or_n), 0);
        @(negedge rd_clk);
        check("R2 not empty after 2 rd edges", int'(empty_or_n), 1);
        repeat (3) @(negedge rd_clk);
        check("R2 word held off bus", int'(rd_data), 0);
        read_pulse();
        check("R2 read delivers word", int'(rd_data), 8'hA5);
        check("R2 empty again", int'(empty_or_n), 0);
        read_pulse();
        check("R8 read on empty holds data", int'(rd_data), 8'hA5);

        for (int i = 0; i < NVEC; i++) begin
            write_word(VEC[i]);
            if (i == DEPTH/2 - 1) check("R6 half flag at DEPTH/2", int'(half_full_n), 1);
        end
        check("R6 half flag above DEPTH/2", int'(half_full_n), 0);
        repeat (3) @(negedge rd_clk);
        for (int i = 0; i < NVEC; i++) begin
            read_pulse();
            check("R2 vector readback", int'(rd_data), int'(VEC[i]));
        end
        check("R8 empty after vectors", int'(empty_or_n), 0);

        rt_pulse();
        check("R11 std rewind shows data", int'(empty_or_n), 1);
        read_pulse();
        check("R11 std first word again", int'(rd_data), 8'hA5);

        do_prst();
        check("R10 std mode kept, empty", int'(empty_or_n), 0);
        check("R10 std mode kept, not full", int'(full_ir_n), 1);

        for (int i = 0; i < DEPTH; i++) write_word(8'h40 + 8'(i));
        check("R5 std full flag", int'(full_ir_n), 0);
        write_word(8'hEE);
        check("R5 std still full", int'(full_ir_n), 0);
        repeat (3) @(negedge rd_clk);
        for (int i = 0; i < DEPTH; i++) begin
            read_pulse();
            check("R7 no overwrite when full", int'(rd_data), 8'h40 + i);
        end
        check("R8 empty after draining", int'(empty_or_n), 0);
        repeat (4) @(negedge wr_clk);
        check("R6 half flag clears", int'(half_full_n), 1);

        // ---------------- fall-through mode ----------------
        do_mrst(1'b1);
        check("R9 fwft not ready", int'(empty_or_n), 1);
        check("R9 fwft input ready", int'(full_ir_n), 0);
        check("R1 strap change after reset ignored", int'(full_ir_n), 0);

        write_word(8'h3C);
        @(negedge rd_clk);
        check("R3 not ready after 1 edge", int'(empty_or_n), 1);
        @(negedge rd_clk);
        check("R3 not ready after 2 edges", int'(empty_or_n), 1);
        @(negedge rd_clk);
        check("R3 ready after 3 edges", int'(empty_or_n), 0);
        check("R3 word on bus", int'(rd_data), 8'h3C);
        write_word(8'h4D);
        write_word(8'h5E);
        repeat (4) @(negedge rd_clk);
        check("R4 head holds without read", int'(rd_data), 8'h3C);
        read_pulse();
        check("R4 advance to second", int'(rd_data), 8'h4D);
        read_pulse();
        check("R4 advance to third", int'(rd_data), 8'h5E);
        read_pulse();
        check("R4 not ready when drained", int'(empty_or_n), 1);
        check("R8 data held when drained", int'(rd_data), 8'h5E);
        read_pulse();
        check("R8 read with nothing ready", int'(rd_data), 8'h5E);

        rt_pulse();
        @(negedge rd_clk);
        check("R11 fwft reload ready", int'(empty_or_n), 0);
        check("R11 fwft first word again", int'(rd_data), 8'h3C);

        do_prst();
        check("R10 fwft mode kept, not ready", int'(empty_or_n), 1);
        check("R10 fwft mode kept, input ready", int'(full_ir_n), 0);

        for (int i = 0; i <= DEPTH; i++) write_word(8'h80 + 8'(i));
        repeat (6) @(negedge wr_clk);
        check("R5 fwft input not ready at DEPTH+1", int'(full_ir_n), 1);
        check("R6 fwft half flag", int'(half_full_n), 0);
        write_word(8'hEE);
        @(negedge rd_clk);
        check("R4 head word", int'(rd_data), 8'h80);
        for (int i = 1; i <= DEPTH; i++) begin
            read_pulse();
            check("R7 fwft no overwrite", int'(rd_data), 8'h80 + i);
        end
        read_pulse();
        check("R4 drained", int'(empty_or_n), 1);
        repeat (4) @(negedge wr_clk);
        check("R5 fwft input ready again", int'(full_ir_n), 0);

        // ---------------- back to standard ----------------
        do_mrst(1'b0);
        check("R1 new master reset picks std", int'(empty_or_n), 0);
        check("R9 std not full", int'(full_ir_n), 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule